// File: doc/BRIEF.md
# Battery Temperature Zone Charge Governor

This block sorts the battery temperature into one of five zones (cold, cool, normal, warm, hot). It works from digitized thermistor comparator results. A fixed comparator marks the cold limit and another fixed comparator marks the hot limit. For each of the cool and warm boundaries, the block receives a bank of comparators and a configuration field picks which one is used. The chosen zone only takes effect after the same classification has been seen on several consecutive clock samples.

From the settled zone the block derives four things: a charge-current scale code, a charge-voltage reduction code, a charge-enable level and a clock enable for the charging safety timer. In the outer zones charging is suspended. In the cool zone the current can be scaled down, and in the warm zone the voltage can be lowered. Either of these two zones can also be set to suspend. The block also evaluates charge termination from three status inputs. It keeps one status bit and one sticky flag per non-normal zone. When an unmasked flag goes from clear to set, it raises a fixed-length interrupt pulse. Two write-only configuration words hold all settings.

Top module: `thermZoneGov`

## Requirements
- R1: The raw zone is chosen in this priority order. Hot if `hotCmp`=1. Otherwise cold if `coldCmp`=1. Otherwise warm if `warmCmp[warmSel]`=1. Otherwise cool if `coolCmp[coolSel]`=1. Otherwise normal. `coolSel` is word 0 bits [1:0] and `warmSel` is word 0 bits [3:2].
- R2: The settled zone changes only at the DEB_LEN-th consecutive clock edge that samples the same new raw zone. A shorter excursion leaves the zone, the status bits and the flags unchanged.
- R3: `zoneStat` is one-hot zero, with bit3 = hot, bit2 = warm, bit1 = cool and bit0 = cold. It is all zero in the normal zone.
- R4: In the cold and hot zones, `chgEnable`=0, `iScale`=00, `vDrop`=0 and `tmrTick` stays low.
- R5: In the cool zone, `iScale` equals the field in word 0 bits [5:4]. The codes are 00 = suspend, 01 = 20 %, 10 = 40 % and 11 = 100 %. `chgEnable` is 1 exactly when the code is non-zero, and `vDrop`=0.
- R6: In the warm zone, the field in word 1 bits [2:0] sets the behaviour. A value of 000 suspends charging (`chgEnable`=0, `iScale`=00). Any other value gives `vDrop` equal to the field with `iScale`=11. In the normal zone, `iScale`=11, `vDrop`=0 and `chgEnable`=1.
- R7: `tmrTick` follows `baseTick` as follows. It follows every pulse when `iScale`=11. It follows every second pulse when `iScale` is 01 or 10. It never follows when `iScale`=00.
- R8: `chgTerm` is 1 when all of these hold: the termination enable (word 0 bit 6) is set, `chgEnable`=1, `curBelowTerm`=1, `vbatAboveRechg`=1 and `cvLoop`=1. This rule is the same in every zone.
- R9: When the ignore bit (word 0 bit 7) is set, `zoneStat` reads 0 from the next cycle and the charge outputs take their normal-zone values. No flag is set.
- R10: When the settled zone changes to a non-normal zone, the flag bit for that zone is set (same bit order as R3). Flags stay set until `flagRdStb` clears them.
- R11: A flag going from 0 to 1 raises `intPulse` for INT_LEN cycles, starting in the cycle the zone settles. This happens only if its mask bit is 0. The mask is word 1 bits [6:3] in R3 order. A masked flag still sets.
- R12: After reset, word 0 = 0x55 and word 1 = 0x03. The zone is normal, the flags are clear and `intPulse`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWr | input | 1 | Configuration write strobe |
| cfgAddr | input | 1 | Configuration word select |
| cfgWdata | input | CFG_W (8) | Configuration write data |
| coldCmp | input | 1 | Temperature below the fixed cold limit |
| hotCmp | input | 1 | Temperature above the fixed hot limit |
| coolCmp | input | NSEL (4) | Below each candidate cool boundary |
| warmCmp | input | NSEL (4) | Above each candidate warm boundary |
| baseTick | input | 1 | Full-rate safety timer tick |
| curBelowTerm | input | 1 | Charge current below termination level |
| vbatAboveRechg | input | 1 | Battery voltage above recharge level |
| cvLoop | input | 1 | Charger in constant-voltage regulation |
| flagRdStb | input | 1 | Host read strobe that clears the flags |
| zoneStat | output | 4 | Settled zone status |
| flags | output | 4 | Sticky zone-entry flags |
| intPulse | output | 1 | Host interrupt pulse |
| chgEnable | output | 1 | Charging allowed |
| iScale | output | 2 | Charge current scale code |
| vDrop | output | 3 | Charge voltage reduction steps |
| tmrTick | output | 1 | Safety timer clock enable |
| chgTerm | output | 1 | Termination condition met |

## Verification
The settled zone, the status bits, the flags and the start of the interrupt pulse all change at the DEB_LEN-th clock edge after a new comparator pattern is applied. The charge outputs and `chgTerm` follow that same edge combinationally. The bench changes configuration one edge before the comparators, so no partly-updated classification is ever sampled. It then checks the old status one edge short of the settling edge and the new status after it. It counts interrupt-high samples across a window that covers the whole pulse. Timer ticks are counted over eight held `baseTick` cycles, which makes the half-rate count independent of the starting phase.

// File: rtl/thermZonePkg.sv
package thermZonePkg;

  typedef enum logic [2:0] {
    ZN_NORMAL = 3'd0,
    ZN_COLD   = 3'd1,
    ZN_COOL   = 3'd2,
    ZN_WARM   = 3'd3,
    ZN_HOT    = 3'd4
  } zone_e;

  // control -> datapath strobes
  typedef struct packed {
    zone_e zone;
    logic  zoneChg;
  } govStrobe_t;

  // bit3 hot, bit2 warm, bit1 cool, bit0 cold
  function automatic logic [3:0] zoneBits(zone_e z);
    case (z)
      ZN_COLD: return 4'b0001;
      ZN_COOL: return 4'b0010;
      ZN_WARM: return 4'b0100;
      ZN_HOT:  return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/tzCtrl.sv
module tzCtrl
  import thermZonePkg::*;
#(
  parameter int DEB_LEN = 3,
  parameter int INT_LEN = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  zone_e      rawZone,
  input  logic [3:0] maskBits,
  input  logic       flagRdStb,
  output govStrobe_t ctl,
  output logic [3:0] flags,
  output logic       intPulse
);

  localparam int CNT_W = $clog2(DEB_LEN + 1);
  localparam int INT_W = $clog2(INT_LEN + 1);
  localparam logic [CNT_W:0]   DEB_V = (CNT_W + 1)'(DEB_LEN);
  localparam logic [INT_W-1:0] INT_V = INT_W'(INT_LEN);

  zone_e            zoneQ, candQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W:0]   runLen;
  logic             commit;
  logic [3:0]       flagsQ, setVec, newlySet;
  logic [INT_W-1:0] intCntQ;

  // length of the current run of identical raw samples, this one included
  always_comb begin
    runLen   = (rawZone == candQ) ? ({1'b0, cntQ} + 1'b1) : (CNT_W + 1)'(1);
    commit   = (rawZone != zoneQ) && (runLen >= DEB_V);
    setVec   = commit ? zoneBits(rawZone) : 4'b0000;
    newlySet = setVec & ~flagsQ & ~maskBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zoneQ <= ZN_NORMAL;
      candQ <= ZN_NORMAL;
      cntQ  <= '0;
    end else begin
      candQ <= rawZone;
      if (commit) zoneQ <= rawZone;
      if (rawZone == zoneQ || commit) cntQ <= '0;
      else                            cntQ <= runLen[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ  <= '0;
      intCntQ <= '0;
    end else begin
      flagsQ <= (flagRdStb ? 4'b0000 : flagsQ) | setVec;
      if (|newlySet)        intCntQ <= INT_V;
      else if (intCntQ != 0) intCntQ <= intCntQ - 1'b1;
    end
  end

  assign ctl.zone    = zoneQ;
  assign ctl.zoneChg = commit;
  assign flags       = flagsQ;
  assign intPulse    = (intCntQ != '0);

  AST_ZONE_DEBOUNCED: assert property (@(posedge clk) disable iff (!rstN)
    (zoneQ != $past(zoneQ)) |-> ($past(rawZone) == zoneQ)); // R2

  AST_INT_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intPulse) |-> (flagsQ != 4'b0000)); // R11

  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    ($past(flagRdStb) && !$past(commit)) |-> (flagsQ == 4'b0000)); // R10

endmodule

// File: rtl/tzDatapath.sv
module tzDatapath
  import thermZonePkg::*;
#(
  parameter  int SEL_W = 2,
  localparam int NSEL  = 1 << SEL_W,
  localparam int CFG_W = 2 * SEL_W + 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic             cfgAddr,
  input  logic [CFG_W-1:0] cfgWdata,
  input  logic             coldCmp,
  input  logic             hotCmp,
  input  logic [NSEL-1:0]  coolCmp,
  input  logic [NSEL-1:0]  warmCmp,
  input  logic             baseTick,
  input  logic             curBelowTerm,
  input  logic             vbatAboveRechg,
  input  logic             cvLoop,
  input  govStrobe_t       ctl,
  output zone_e            rawZone,
  output logic [3:0]       maskBits,
  output logic [3:0]       zoneStat,
  output logic             chgEnable,
  output logic [1:0]       iScale,
  output logic [2:0]       vDrop,
  output logic             tmrTick,
  output logic             chgTerm
);

  localparam logic [CFG_W-1:0] RST0 = {1'b0, 1'b1, 2'b01, SEL_W'(1), SEL_W'(1)};
  localparam logic [6:0]       RST1 = 7'b0000_011;

  logic [CFG_W-1:0] cfg0Q;
  logic [6:0]       cfg1Q;
  logic [SEL_W-1:0] coolSel, warmSel;
  logic [1:0]       coolISet;
  logic [2:0]       warmVSet;
  logic             termEn, tsIgnore, halfMode, halfPhQ;
  zone_e            effZone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg0Q <= RST0;
      cfg1Q <= RST1;
    end else if (cfgWr) begin
      if (!cfgAddr) cfg0Q <= cfgWdata;
      else          cfg1Q <= cfgWdata[6:0];
    end
  end

  assign coolSel  = cfg0Q[SEL_W-1:0];
  assign warmSel  = cfg0Q[2*SEL_W-1:SEL_W];
  assign coolISet = cfg0Q[2*SEL_W+1:2*SEL_W];
  assign termEn   = cfg0Q[2*SEL_W+2];
  assign tsIgnore = cfg0Q[2*SEL_W+3];
  assign warmVSet = cfg1Q[2:0];
  assign maskBits = cfg1Q[6:3];

  // raw classification, outer limits take priority
  always_comb begin
    if (tsIgnore)               rawZone = ZN_NORMAL;
    else if (hotCmp)            rawZone = ZN_HOT;
    else if (coldCmp)           rawZone = ZN_COLD;
    else if (warmCmp[warmSel])  rawZone = ZN_WARM;
    else if (coolCmp[coolSel])  rawZone = ZN_COOL;
    else                        rawZone = ZN_NORMAL;
  end

  assign effZone  = tsIgnore ? ZN_NORMAL : ctl.zone;
  assign zoneStat = zoneBits(effZone);

  always_comb begin
    chgEnable = 1'b1;
    iScale    = 2'b11;
    vDrop     = 3'd0;
    case (effZone)
      ZN_COLD, ZN_HOT: begin
        chgEnable = 1'b0;
        iScale    = 2'b00;
      end
      ZN_COOL: begin
        chgEnable = (coolISet != 2'b00);
        iScale    = coolISet;
      end
      ZN_WARM: begin
        chgEnable = (warmVSet != 3'd0);
        iScale    = (warmVSet != 3'd0) ? 2'b11 : 2'b00;
        vDrop     = warmVSet;
      end
      default: ;
    endcase
  end

  assign halfMode = (iScale == 2'b01) || (iScale == 2'b10);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     halfPhQ <= 1'b0;
    else if (ctl.zoneChg)          halfPhQ <= 1'b0;
    else if (baseTick && halfMode) halfPhQ <= ~halfPhQ;
  end

  assign tmrTick = baseTick && ((iScale == 2'b11) || (halfMode && halfPhQ));
  assign chgTerm = termEn && chgEnable && curBelowTerm && vbatAboveRechg && cvLoop;

  AST_HALF_RATE: assert property (@(posedge clk) disable iff (!rstN)
    (tmrTick && halfMode && $past(halfMode)) |-> !$past(tmrTick)); // R7

  AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $past(tsIgnore) && tsIgnore |-> (zoneStat == 4'b0000) && chgEnable); // R9

endmodule

// File: rtl/thermZoneGov.sv
module thermZoneGov
  import thermZonePkg::*;
#(
  parameter  int SEL_W   = 2,
  parameter  int DEB_LEN = 3,
  parameter  int INT_LEN = 2,
  localparam int NSEL    = 1 << SEL_W,
  localparam int CFG_W   = 2 * SEL_W + 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic             cfgAddr,
  input  logic [CFG_W-1:0] cfgWdata,
  input  logic             coldCmp,
  input  logic             hotCmp,
  input  logic [NSEL-1:0]  coolCmp,
  input  logic [NSEL-1:0]  warmCmp,
  input  logic             baseTick,
  input  logic             curBelowTerm,
  input  logic             vbatAboveRechg,
  input  logic             cvLoop,
  input  logic             flagRdStb,
  output logic [3:0]       zoneStat,
  output logic [3:0]       flags,
  output logic             intPulse,
  output logic             chgEnable,
  output logic [1:0]       iScale,
  output logic [2:0]       vDrop,
  output logic             tmrTick,
  output logic             chgTerm
);

  govStrobe_t ctl;
  zone_e      rawZone;
  logic [3:0] maskBits;

  tzCtrl #(.DEB_LEN(DEB_LEN), .INT_LEN(INT_LEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .rawZone(rawZone), .maskBits(maskBits),
    .flagRdStb(flagRdStb), .ctl(ctl), .flags(flags), .intPulse(intPulse)
  );

  tzDatapath #(.SEL_W(SEL_W)) dp_i (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .coldCmp(coldCmp), .hotCmp(hotCmp), .coolCmp(coolCmp), .warmCmp(warmCmp),
    .baseTick(baseTick), .curBelowTerm(curBelowTerm), .vbatAboveRechg(vbatAboveRechg),
    .cvLoop(cvLoop), .ctl(ctl), .rawZone(rawZone), .maskBits(maskBits),
    .zoneStat(zoneStat), .chgEnable(chgEnable), .iScale(iScale), .vDrop(vDrop),
    .tmrTick(tmrTick), .chgTerm(chgTerm)
  );

  AST_COLDHOT_SUSPEND: assert property (@(posedge clk) disable iff (!rstN)
    (zoneStat[0] || zoneStat[3]) |-> (!chgEnable && !tmrTick)); // R4

  AST_WARM_FULL_CURRENT: assert property (@(posedge clk) disable iff (!rstN)
    (zoneStat[2] && chgEnable) |-> (iScale == 2'b11)); // R6

  AST_STAT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(zoneStat) && $onehot0(flags & ~flags)); // R3

endmodule

// File: tb/thermZoneGov_tb.sv
module thermZoneGov_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEB_LEN    = 3;
  localparam int INT_LEN    = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWr = 1'b0, cfgAddr = 1'b0;
  logic [7:0] cfgWdata = '0;
  logic       coldCmp = 1'b0, hotCmp = 1'b0;
  logic [3:0] coolCmp = '0, warmCmp = '0;
  logic       baseTick = 1'b0, curBelowTerm = 1'b0, vbatAboveRechg = 1'b0, cvLoop = 1'b0;
  logic       flagRdStb = 1'b0;
  logic [3:0] zoneStat, flags;
  logic       intPulse, chgEnable, tmrTick, chgTerm;
  logic [1:0] iScale;
  logic [2:0] vDrop;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  thermZoneGov #(.SEL_W(2), .DEB_LEN(DEB_LEN), .INT_LEN(INT_LEN)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .coldCmp(coldCmp), .hotCmp(hotCmp), .coolCmp(coolCmp), .warmCmp(warmCmp),
    .baseTick(baseTick), .curBelowTerm(curBelowTerm), .vbatAboveRechg(vbatAboveRechg),
    .cvLoop(cvLoop), .flagRdStb(flagRdStb), .zoneStat(zoneStat), .flags(flags),
    .intPulse(intPulse), .chgEnable(chgEnable), .iScale(iScale), .vDrop(vDrop),
    .tmrTick(tmrTick), .chgTerm(chgTerm)
  );

  // zone codes of the bench model: 0 normal, 1 cold, 2 cool, 3 warm, 4 hot
  function automatic int classify(bit cold, bit hot, bit [3:0] cool, bit [3:0] warm, bit [7:0] r0);
    if (r0[7])         return 0;
    if (hot)           return 4;
    if (cold)          return 1;
    if (warm[r0[3:2]]) return 3;
    if (cool[r0[1:0]]) return 2;
    return 0;
  endfunction

  function automatic int statOf(int z);
    case (z)
      1: return 1;
      2: return 2;
      3: return 4;
      4: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic int scaleOf(int z, bit [7:0] r0, bit [7:0] r1);
    if (z == 1 || z == 4) return 0;
    if (z == 2) return int'(r0[5:4]);
    if (z == 3) return (r1[2:0] != 0) ? 3 : 0;
    return 3;
  endfunction

  function automatic int dropOf(int z, bit [7:0] r1);
    return (z == 3) ? int'(r1[2:0]) : 0;
  endfunction

  function automatic int tickOf(int scale);
    if (scale == 3) return 8;
    if (scale == 0) return 0;
    return 4;
  endfunction

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic wrCfg(bit a, bit [7:0] d);
    @(negedge clk);
    cfgWr = 1'b1; cfgAddr = a; cfgWdata = d;
  endtask

  task automatic waitEdges(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    int prevZone;
    bit [7:0] r0, r1;
    void'($urandom(32'h5EED_0017));
    waitEdges(3);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 zoneStat", zoneStat, 0);
    chk("R12 flags", flags, 0);
    chk("R12 intPulse", intPulse, 0);
    chk("R6 normal iScale", iScale, 3);
    chk("R6 normal chgEnable", chgEnable, 1);
    curBelowTerm = 1; vbatAboveRechg = 1; cvLoop = 1;
    #1 chk("R8 R12 term enabled after reset", chgTerm, 1);
    // reset coolSel=01 and coolISet=20%
    coolCmp = 4'b0010;
    waitEdges(DEB_LEN);
    chk("R12 R5 cool via reset select", zoneStat, 2);
    chk("R12 R5 reset 20% scale", iScale, 1);
    chk("R10 cool flag", flags, 2);
    coolCmp = 4'b0000;
    waitEdges(DEB_LEN + 2);
    chk("R2 back to normal", zoneStat, 0);
    prevZone = 0;
    r0 = 8'h55; r1 = 8'h03;

    for (int it = 0; it < 60; it++) begin
      int newZone, expFlags, intCnt, tk, sc;
      bit cd, ht;
      bit [3:0] cl, wm;
      bit b, a, c;
      r1 = 8'($urandom) & 8'h7F;
      r0 = 8'($urandom) & 8'h7F;
      if (($urandom % 4) == 0) r0[7] = 1'b1;
      cd = (($urandom % 5) == 0);
      ht = (($urandom % 5) == 0);
      cl = 4'($urandom);
      wm = 4'($urandom);
      if (it == 5) begin r0 = 8'h00; ht = 0; cd = 0; wm = 0; cl = 4'b0001; end  // cool suspend
      if (it == 6) begin r1 = 8'h00; r0[7] = 0; ht = 0; cd = 0; wm = 4'hF; end   // warm suspend
      @(negedge clk);
      cfgWr = 1'b1; cfgAddr = 1'b1; cfgWdata = r1; flagRdStb = 1'b1;
      @(negedge clk);
      cfgAddr = 1'b0; cfgWdata = r0; flagRdStb = 1'b0;
      @(negedge clk);
      cfgWr = 1'b0;
      coldCmp = cd; hotCmp = ht; coolCmp = cl; warmCmp = wm;
      newZone = classify(cd, ht, cl, wm, r0);
      expFlags = (newZone != prevZone && newZone != 0) ? statOf(newZone) : 0;
      intCnt = 0;
      for (int k = 1; k <= DEB_LEN + INT_LEN + 1; k++) begin
        @(negedge clk);
        if (intPulse) intCnt++;
        if (k == DEB_LEN - 1)
          chk("R2 zone held before debounce", zoneStat, r0[7] ? 0 : statOf(prevZone));
      end
      chk("R1 R3 R9 zoneStat", zoneStat, r0[7] ? 0 : statOf(newZone));
      chk("R10 flags", flags, expFlags);
      chk("R11 int pulse cycles", intCnt, ((expFlags & ~int'(r1[6:3])) != 0) ? INT_LEN : 0);
      sc = scaleOf(newZone, r0, r1);
      chk("R4 R5 R6 iScale", iScale, sc);
      chk("R4 R5 R6 chgEnable", chgEnable, sc != 0);
      chk("R6 vDrop", vDrop, dropOf(newZone, r1));
      b = 1'($urandom); a = 1'($urandom); c = 1'($urandom);
      if (($urandom % 2) == 0) begin b = 1; a = 1; c = 1; end
      curBelowTerm = b; vbatAboveRechg = a; cvLoop = c;
      #1 chk("R8 chgTerm", chgTerm, r0[6] && (sc != 0) && b && a && c);
      tk = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        baseTick = 1'b1;
        #1 if (tmrTick) tk++;
      end
      @(negedge clk);
      baseTick = 1'b0;
      chk("R7 timer ticks", tk, tickOf(sc));
      prevZone = newZone;
    end

    // R2 glitch shorter than the debounce window
    wrCfg(1'b0, 8'h55);
    @(negedge clk);
    cfgWr = 1'b0; flagRdStb = 1'b1;
    coldCmp = 0; hotCmp = 0; coolCmp = 0; warmCmp = 0;
    waitEdges(DEB_LEN + 1);
    flagRdStb = 1'b0;
    waitEdges(1);
    hotCmp = 1'b1;
    waitEdges(DEB_LEN - 1);
    hotCmp = 1'b0;
    waitEdges(DEB_LEN + 2);
    chk("R2 glitch zoneStat", zoneStat, 0);
    chk("R2 glitch flags", flags, 0);
    chk("R2 glitch chgEnable", chgEnable, 1);

    finishRun();
  end

endmodule